// File: doc/BRIEF.md
# Multi-view video memory address remapper

This block sits between a bus port that sees a 64 MB video aperture and a byte-wide video memory of at most 16 MB. The aperture holds four aliased windows onto the same memory. Address bits 25:24 pick the window:

- a plain packed window;
- a packed window that cannot overwrite the first (X) byte of each 4-byte pixel;
- a window that splits 2-byte pixels into two byte planes;
- a window that splits 4-byte pixels into four byte planes.

Each window turns the request address into a memory byte offset with a shift and a plane select taken from high address bits.

A request is a byte, a halfword or a word. A small state machine breaks each request into byte lanes and issues one lane per cycle to the memory. Writes are gated per lane. Read bytes are gathered, most significant first, into a right-aligned result. When a request retires, a one-cycle pulse reports whether it actually wrote any byte, so a refresh engine can mark the frame dirty.

The machine has three states:

| State | Behaviour | Transition out |
|---|---|---|
| `ST_IDLE` | Only state with `req_ready` high | ACCEPT: request handshake, to `ST_ISSUE` |
| `ST_ISSUE` | One memory access per cycle | STEP: next lane, stays in `ST_ISSUE`; FINISH: last lane, to `ST_DONE` |
| `ST_DONE` | Drives the response | RETIRE: back to `ST_IDLE` |

Top module: `vram_view_xlate`

## Requirements
- R1: `req_addr[25:24]` selects the window: 0 = packed, 1 = X-protected packed, 2 = 2-byte-pixel planes, 3 = 4-byte-pixel planes.
- R2: In windows 0 and 1 the byte offset is `req_addr & (MEM_BYTES-1)`. A word covers offsets +0..+3, and its most significant byte is at the lowest offset.
- R3: In window 1 a write lane whose final offset has bits 1:0 equal to 00 issues no memory write. Reads in window 1 return the same bytes as window 0.
- R4: In window 2 the offset is `((addr<<1) & mask) + addr[23]`. A word covers offsets +0, +2, +4 and +6, most significant byte first.
- R5: In window 3 the offset is `((addr<<2) & mask) + addr[23:22]`. A word covers offsets +0, +4, +8 and +12, most significant byte first.
- R6: `req_size` 0 is a byte, 1 is a halfword, 2 is a word, and 3 is handled as a word. Read data is right-aligned and zero-extended.
- R7: A halfword is two byte accesses at `addr` and `addr+1`, each mapped through the window on its own. The high data byte goes to `addr`.
- R8: `req_ready` is high only in `ST_IDLE`. A request is taken when `req_valid && req_ready`. Its lanes go to memory one per cycle, in consecutive cycles, starting the cycle after acceptance.
- R9: `rsp_valid` is a one-cycle pulse exactly (lanes + 1) cycles after acceptance, where lanes is 1, 2 or 4. `rsp_rdata` carries read data with it and is zero for writes.
- R10: `wr_pulse` is high for one cycle, together with `rsp_valid`, exactly when at least one lane of the request wrote memory.
- R11: During and right after reset the block is in `ST_IDLE`: `req_ready` is 1, and `mem_en`, `rsp_valid` and `wr_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 26 | Aperture address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Request retired |
| rsp_rdata | output | 32 | Read result, right-aligned |
| wr_pulse | output | 1 | Retired request wrote at least one byte |
| mem_en | output | 1 | Memory byte access this cycle |
| mem_we | output | 1 | Write enable for the addressed byte |
| mem_addr | output | $clog2(MEM_BYTES) | Memory byte offset |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after `mem_en` |

## Verification
The in-line assertions watch the properties that hold on every cycle:
- a write never lands on an X byte through window 1;
- `req_ready` drops after every acceptance;
- memory accesses happen only while busy;
- a write enable never appears without an access;
- the response and the write pulse each last a single cycle and coincide.

Only the bench scenarios can show that the offsets are right. They write through one window and read back through another, and so expose the per-window address arithmetic, the plane interleaving, the byte order, halfword splitting and address masking. The bench also measures the response latency for each access size.

// File: rtl/vxl_pkg.sv
package vxl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        VW_PACKED = 2'd0,
        VW_XSAFE  = 2'd1,
        VW_PAIR   = 2'd2,
        VW_CHAN   = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } xl_state_e;

    localparam int APER_W = 26;

    function automatic logic [2:0] lane_count(xfer_size_e sz);
        unique case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/vxl_map.sv
module vxl_map
    import vxl_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic [APER_W-1:0] addr,
    input  xfer_size_e        size,
    input  logic [1:0]        lane,
    output view_e             view,
    output logic [AW-1:0]     off
);
    logic [APER_W-1:0] eff;
    logic [AW-1:0]     raw;
    logic [AW-1:0]     step;

    always_comb begin
        view = view_e'(addr[25:24]);
        // R7: halfword lanes map addr and addr+1 independently
        eff  = (size == SZ_HALF) ? addr + APER_W'(lane) : addr;
        unique case (view)
            VW_PAIR: raw = {eff[AW-2:0], 1'b0} + AW'(eff[23]);       // R4
            VW_CHAN: raw = {eff[AW-3:0], 2'b00} + AW'(eff[23:22]);   // R5
            default: raw = eff[AW-1:0];                              // R2
        endcase
        step = '0;
        if (size == SZ_WORD || size == SZ_WIDE) begin
            unique case (view)
                VW_PAIR: step = AW'({lane, 1'b0});
                VW_CHAN: step = AW'({lane, 2'b00});
                default: step = AW'(lane);
            endcase
        end
        off = raw + step;
    end
endmodule

// File: rtl/vxl_gather.sv
module vxl_gather (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        shift,
    input  logic [7:0]  byte_in,
    output logic [31:0] word_out
);
    logic [23:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (shift)    acc_q <= {acc_q[15:0], byte_in};
    end

    assign word_out = {acc_q, byte_in};
endmodule

// File: rtl/vram_view_xlate.sv
module vram_view_xlate
    import vxl_pkg::*;
#(
    parameter int MEM_BYTES = 8388608,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [25:0]   req_addr,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          wr_pulse,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    xl_state_e         state_q, state_d;
    logic [1:0]        lane_q;
    logic [APER_W-1:0] addr_q;
    xfer_size_e        size_q;
    logic              wr_q;
    logic [31:0]       wdata_q;
    logic              anywr_q;
    logic [2:0]        nlanes;
    logic              last_lane;
    logic              accept;
    logic              blocked;
    logic [2:0]        byte_idx;
    logic [31:0]       gathered;
    view_e             view;
    logic [AW-1:0]     off;

    assign nlanes    = lane_count(size_q);
    assign last_lane = ({1'b0, lane_q} == nlanes - 3'd1);
    assign accept    = req_valid && req_ready;

    vxl_map #(.AW(AW)) map_i (
        .addr (addr_q),
        .size (size_q),
        .lane (lane_q),
        .view (view),
        .off  (off)
    );

    vxl_gather gather_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .shift    (state_q == ST_ISSUE && lane_q != 2'd0 && !wr_q),
        .byte_in  (mem_rdata),
        .word_out (gathered)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT, STEP, FINISH, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: if (last_lane) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request and lane datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q  <= '0;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            anywr_q <= 1'b0;
        end else if (accept) begin
            lane_q  <= '0;
            addr_q  <= req_addr;
            size_q  <= xfer_size_e'(req_size);
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            anywr_q <= 1'b0;
        end else if (state_q == ST_ISSUE) begin
            lane_q  <= lane_q + 2'd1;
            anywr_q <= anywr_q | mem_we;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        wr_pulse  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        blocked   = (view == VW_XSAFE) && (off[1:0] == 2'b00);
        byte_idx  = nlanes - 3'd1 - {1'b0, lane_q};
        mem_addr  = off;
        mem_wdata = 8'(wdata_q >> {byte_idx, 3'b000});
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                mem_en = 1'b1;
                mem_we = wr_q && !blocked;
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_rdata = wr_q ? 32'd0 : gathered;
                wr_pulse  = anywr_q;
            end
            default: ;
        endcase
    end

    // R3: no byte write ever reaches an X byte through the protected window
    p_xsafe_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(view == VW_XSAFE && mem_addr[1:0] == 2'b00));

    // R8: acceptance makes the block busy on the next cycle
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: memory is only touched while a request is in flight
    p_mem_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready);

    // R8: a write enable never appears without an access
    p_we_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R9: the response is a single-cycle pulse
    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: the write pulse only comes with the response
    p_pulse_with_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> rsp_valid);

    // R10: a write pulse follows an access that wrote memory
    p_pulse_after_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(mem_we) && !$past(anywr_q)) |-> !wr_pulse);
endmodule

// File: tb/vram_view_xlate_tb_top.sv
`timescale 1ns/1ps
module vram_view_xlate_tb_top;
    localparam int MEMB = 4096;
    localparam int AW   = $clog2(MEMB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [25:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          wr_pulse;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic [7:0]    mem [MEMB];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    vram_view_xlate #(.MEM_BYTES(MEMB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_pulse(wr_pulse),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // behavioural byte memory, one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMB; i++) mem[i] <= 8'h00;
            mem_rdata <= 8'h00;
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [1:0] sz, input logic [25:0] a,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output bit pulse, output int lat, output bit busy_rdy,
                         output bit early_pulse);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_rdy = req_ready;
        early_pulse = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 20) begin
            if (wr_pulse) early_pulse = 1'b1;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        pulse = wr_pulse;
    endtask

    function automatic int lanes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    localparam int NV = 22;
    localparam bit V_WR [NV] = '{1,1,1,1,1,1,1,1, 0,0,0,0,0,0,0,0,0,0,0,0,0,0};
    localparam logic [1:0] V_SZ [NV] = '{2,2,2,2,2,1,1,1, 0,2,2,2,2,2,2,0,2,2,2,1,2,2};
    localparam logic [25:0] V_ADDR [NV] = '{
        26'h0000100, 26'h1000200, 26'h2000180, 26'h2800180,
        26'h3400100, 26'h0000500, 26'h3C00140, 26'h1000600,
        26'h0000102, 26'h0000100, 26'h0001100, 26'h0000200,
        26'h1000100, 26'h0000300, 26'h0000304, 26'h2800180,
        26'h0000404, 26'h3400100, 26'h0000500, 26'h0000500,
        26'h0000504, 26'h0000600};
    localparam logic [31:0] V_DATA [NV] = '{
        32'h11223344, 32'hAABBCCDD, 32'h01020304, 32'h05060708,
        32'hA1A2A3A4, 32'h0000BEEF, 32'h00001234, 32'h00005566,
        32'h00000033, 32'h11223344, 32'h11223344, 32'h00BBCCDD,
        32'h11223344, 32'h01050206, 32'h03070408, 32'h00000005,
        32'h00A20000, 32'hA1A2A3A4, 32'hBEEF0012, 32'h0000BEEF,
        32'h00000034, 32'h00660000};
    localparam string V_TAG [NV] = '{
        "R2", "R3", "R4", "R4", "R5", "R7", "R7", "R3",
        "R2", "R2", "R2", "R3", "R3", "R4", "R4", "R4",
        "R5", "R5", "R7", "R6", "R7", "R3"};

    initial begin
        logic [31:0] rd;
        bit pulse, busy_rdy, early;
        int lat;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk(req_ready == 1'b1, "R11 ready in reset", {31'd0, req_ready}, 32'd1);
        chk(mem_en == 1'b0 && rsp_valid == 1'b0 && wr_pulse == 1'b0, "R11 quiet in reset",
            {29'd0, mem_en, rsp_valid, wr_pulse}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_en == 1'b0, "R11 idle after reset",
            {30'd0, req_ready, mem_en}, 32'd2);

        for (int i = 0; i < NV; i++) begin
            do_op(V_WR[i], V_SZ[i], V_ADDR[i], V_DATA[i], rd, pulse, lat, busy_rdy, early);
            if (!V_WR[i])
                chk(rd == V_DATA[i], V_TAG[i], rd, V_DATA[i]);
            else
                chk(rd == 32'd0, "R9 write rdata", rd, 32'd0);
            chk(lat == lanes_of(V_SZ[i]) + 1, "R9 latency", lat, lanes_of(V_SZ[i]) + 1);
            chk(busy_rdy == 1'b0, "R8 busy", {31'd0, busy_rdy}, 32'd0);
            chk(pulse == V_WR[i] && !early, "R10 pulse",
                {30'd0, early, pulse}, {31'd0, V_WR[i]});
        end

        // R3: X-byte write through protected window: nothing written, no pulse
        do_op(1'b1, 2'd0, 26'h1000700, 32'h000000EE, rd, pulse, lat, busy_rdy, early);
        chk(pulse == 1'b0, "R10 no pulse when all lanes dropped", {31'd0, pulse}, 32'd0);
        do_op(1'b0, 2'd0, 26'h0000700, 32'd0, rd, pulse, lat, busy_rdy, early);
        chk(rd == 32'd0, "R3 X byte kept", rd, 32'd0);
        // R3: non-X byte through protected window is written
        do_op(1'b1, 2'd0, 26'h1000701, 32'h00000077, rd, pulse, lat, busy_rdy, early);
        chk(pulse == 1'b1, "R10 pulse on write", {31'd0, pulse}, 32'd1);
        do_op(1'b0, 2'd2, 26'h0000700, 32'd0, rd, pulse, lat, busy_rdy, early);
        chk(rd == 32'h00770000, "R3 neighbour written", rd, 32'h00770000);
        // R1/R5: each channel of window 3 lands on its own byte of the pixel
        do_op(1'b1, 2'd0, 26'h3000200, 32'h00000010, rd, pulse, lat, busy_rdy, early);
        do_op(1'b1, 2'd0, 26'h3800200, 32'h00000030, rd, pulse, lat, busy_rdy, early);
        do_op(1'b0, 2'd2, 26'h0000800, 32'd0, rd, pulse, lat, busy_rdy, early);
        chk(rd == 32'h10003000, "R1 channel select", rd, 32'h10003000);
        // R6: size code 3 behaves as a word
        do_op(1'b0, 2'd3, 26'h0000100, 32'd0, rd, pulse, lat, busy_rdy, early);
        chk(rd == 32'h11223344, "R6 size 3 word", rd, 32'h11223344);
        chk(lat == 5, "R9 size 3 latency", lat, 5);
        // R4: window 2 offset masked to memory size (0x800<<1 wraps to 0)
        do_op(1'b1, 2'd0, 26'h2800800, 32'h0000005A, rd, pulse, lat, busy_rdy, early);
        do_op(1'b0, 2'd0, 26'h0000001, 32'd0, rd, pulse, lat, busy_rdy, early);
        chk(rd == 32'h0000005A, "R4 mask wrap", rd, 32'h0000005A);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule